// File: doc/BRIEF.md
# Command-Completion Register Block

This block is the software-visible register file of a sideband management controller, with the serial wire protocol left out. Software writes a fire bit to launch a command. The command completes on the same clock edge with a fixed success completion code. That code lands in both data buffers, and a command-done event is raised. The event becomes a status bit, and then a level interrupt, if it is enabled.

Access uses a plain 32-bit register bus with single-cycle read and write strobes and a byte address. Accesses are word-aligned. The implemented window is sixteen words, offsets 0x00 to 0x3C, and the word is selected by address bits [5:2].

Registers with behaviour of their own:
- the command register
- the interrupt enable mask
- a write-one-to-clear status register
- the transmit and receive buffer words

Every other offset in the window is plain storage. Anything above the window reads as zero and ignores writes.

Top module: `cmdreg_stub`

## Requirements
- R1: After a synchronous reset, every word in the window reads 0 and `irq` is low.
- R2: A write to any in-window offset other than 0x08 and 0x1C stores all 32 bits, and a later read returns them unchanged.
- R3: The command register at 0x08 always reads 0. A write there with bit 0 clear changes no register and does not move `irq`.
- R4: A fire is accepted when a write to 0x08 has bit 0 set and the status register at 0x1C reads 0. An accepted fire loads 0x40 into the transmit word at 0x20 and into the receive word at 0x30.
- R5: On an accepted fire, the status register is replaced by the enable register at 0x18 ANDed with 0x1. Bit 0 of the status register is command-done.
- R6: A write to 0x08 with bit 0 set while the status register is nonzero is ignored. The buffers at 0x20 and 0x30 and the status register keep their values.
- R7: A write to 0x1C clears each status bit whose written data bit is 1 and leaves the other status bits unchanged. Status never gains a bit except through an accepted fire.
- R8: `irq` is registered. It equals "status nonzero" as of the previous clock edge, so it rises and falls one cycle after the write that changes the status.
- R9: A read at a byte offset of 0x40 or above returns 0. A write there changes no register in the window.
- R10: `rdata` is registered. It shows the addressed word on the cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address, word-aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, registered |

## Verification
The hardest state to reach is a rejected fire. It needs a completed command whose done bit was enabled and has not been cleared yet. The bench reaches it by first loading the buffers with a marker pattern, then enabling command-done, firing, overwriting the buffers with a fresh marker, and firing again. It then checks that the marker survived and the status kept its value. The same sweep covers enable masks that have bit 0 clear, so an accepted fire leaves the status at zero and `irq` low. It also covers partial clears of the status register.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_WORDS = 16;
    localparam int WIDX_W    = $clog2(NUM_WORDS);

    // byte offsets that software decodes
    localparam int OFS_CMD = 'h08;
    localparam int OFS_IEN = 'h18;
    localparam int OFS_STS = 'h1C;
    localparam int OFS_TXB = 'h20;
    localparam int OFS_RXB = 'h30;

    localparam int FIRE_BIT = 0;
    localparam int DONE_BIT = 0;

    localparam logic [DATA_W-1:0] DONE_CODE = DATA_W'('h40);
    localparam logic [DATA_W-1:0] DONE_MASK = DATA_W'(1) << DONE_BIT;

    function automatic logic [WIDX_W-1:0] word_of(input int ofs);
        return WIDX_W'(ofs >> 2);
    endfunction

    localparam logic [WIDX_W-1:0] IDX_CMD = word_of(OFS_CMD);
    localparam logic [WIDX_W-1:0] IDX_IEN = word_of(OFS_IEN);
    localparam logic [WIDX_W-1:0] IDX_STS = word_of(OFS_STS);
    localparam logic [WIDX_W-1:0] IDX_TXB = word_of(OFS_TXB);
    localparam logic [WIDX_W-1:0] IDX_RXB = word_of(OFS_RXB);

    typedef struct packed {
        logic              hit;   // address inside the window
        logic [WIDX_W-1:0] idx;   // word index
    } slot_t;

    typedef logic [NUM_WORDS-1:0][DATA_W-1:0] word_bank_t;

endpackage

// File: rtl/cmdreg_decode.sv
module cmdreg_decode
    import cmdreg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_t             slot
);
    localparam int WINDOW_BYTES = NUM_WORDS * 4;

    always_comb begin
        slot.hit = (int'(addr) < WINDOW_BYTES);
        slot.idx = addr[2 +: WIDX_W];
    end
endmodule

// File: rtl/cmdreg_event.sv
module cmdreg_event
    import cmdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  slot_t             slot,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ien,
    output logic [DATA_W-1:0] sts,
    output logic              fire_acc,
    output logic              irq
);
    logic cmd_wr;
    logic sts_wr;

    always_comb begin
        cmd_wr   = wr_en && slot.hit && (slot.idx == IDX_CMD);
        sts_wr   = wr_en && slot.hit && (slot.idx == IDX_STS);
        fire_acc = cmd_wr && wdata[FIRE_BIT] && (sts == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            irq <= 1'b0;
        end else begin
            if (fire_acc) begin
                sts <= ien & DONE_MASK;
            end else if (sts_wr) begin
                sts <= sts & ~wdata;
            end
            irq <= (sts != '0);
        end
    end

    // R5: accepted fire replaces status with masked done event
    p_fire_sets_sts_r5: assert property (@(posedge clk) disable iff (rst)
        fire_acc |=> (sts == ($past(ien) & DONE_MASK)));

    // R7: without a fire, no status bit can appear
    p_sts_no_new_bits_r7: assert property (@(posedge clk) disable iff (rst)
        !fire_acc |=> ((sts & ~$past(sts)) == '0));

    // R6: a fire request while status pending leaves status alone
    p_fire_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[FIRE_BIT] && (sts != '0)) |=> $stable(sts));
endmodule

// File: rtl/cmdreg_store.sv
module cmdreg_store
    import cmdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  slot_t             slot,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fire_load,
    output word_bank_t        words
);
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        localparam logic [WIDX_W-1:0] GI = WIDX_W'(g);
        if (GI == IDX_CMD || GI == IDX_STS) begin : g_virtual
            // these words are held elsewhere or not retained
            assign words[g] = '0;
        end else begin : g_real
            localparam bit IS_BUF = (GI == IDX_TXB) || (GI == IDX_RXB);
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[g] <= '0;
                end else if (IS_BUF && fire_load) begin
                    words[g] <= DONE_CODE;
                end else if (wr_en && slot.hit && slot.idx == GI) begin
                    words[g] <= wdata;
                end
            end
        end
    end

    // R4: an accepted fire leaves the success code in both buffers
    p_buffers_loaded_r4: assert property (@(posedge clk) disable iff (rst)
        fire_load |=> (words[IDX_TXB] == DONE_CODE && words[IDX_RXB] == DONE_CODE));
endmodule

// File: rtl/cmdreg_stub.sv
module cmdreg_stub
    import cmdreg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    slot_t             slot;
    word_bank_t        words;
    logic [DATA_W-1:0] sts;
    logic              fire_acc;
    logic [DATA_W-1:0] rd_val;

    cmdreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .slot (slot)
    );

    cmdreg_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .slot      (slot),
        .wdata     (wdata),
        .fire_load (fire_acc),
        .words     (words)
    );

    cmdreg_event u_event (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .slot     (slot),
        .wdata    (wdata),
        .ien      (words[IDX_IEN]),
        .sts      (sts),
        .fire_acc (fire_acc),
        .irq      (irq)
    );

    always_comb begin
        if (!slot.hit)                rd_val = '0;
        else if (slot.idx == IDX_STS) rd_val = sts;
        else                          rd_val = words[slot.idx];
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

    // R9: reads outside the window return zero
    p_oob_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !slot.hit) |=> (rdata == '0));

    // R3: the command register never reads back nonzero
    p_cmd_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && slot.hit && slot.idx == IDX_CMD) |=> (rdata == '0));

    // R8: with status clear, the interrupt is low one edge later
    p_irq_low_r8: assert property (@(posedge clk) disable iff (rst)
        (sts == '0) |=> !irq);

    // R10: read data holds while no read strobe
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/cmdreg_stub_tb.sv
`timescale 1ns/1ps
module cmdreg_stub_tb_top;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic              rd_en;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic              irq;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    logic [31:0] m [16];
    logic [31:0] m_sts;

    always #2.5 clk = ~clk;

    cmdreg_stub #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [31:0] exp_word(input int i);
        if (i == 2) return 32'h0;
        if (i == 7) return m_sts;
        return m[i];
    endfunction

    function automatic logic [31:0] pat(input int i, input int salt);
        return (32'(i + 1) * 32'h11111111) ^ 32'hC3C3C3C3 ^ (32'(salt) << 8);
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int i = 0; i < 16; i++) begin
            rd(i * 4, d);
            chk($sformatf("%s word%0d", tag, i), d, exp_word(i));
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] en_list [7];
        en_list = '{32'h0, 32'h1, 32'h2, 32'h3, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h5};
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        for (int i = 0; i < 16; i++) m[i] = 32'h0;
        m_sts = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        check_all("R1 reset");

        // R2: plain storage sweep over every ordinary word
        for (int i = 0; i < 16; i++) begin
            if (i == 2 || i == 7) continue;
            wr(i * 4, pat(i, 0));
            m[i] = pat(i, 0);
        end
        check_all("R2 store");

        // R10: read data holds with no strobe while address moves
        rd(5 * 4, d);
        @(negedge clk); addr = ADDR_W'(9 * 4);
        @(negedge clk);
        chk("R10 hold", rdata, m[5]);

        // R9: out-of-window writes discarded, reads zero
        foreach (en_list[k]) begin end
        for (int a = 'h40; a < 'h1000; a += 'h3C4) begin
            wr(a, 32'hDEADBEEF);
            rd(a, d);
            chk($sformatf("R9 oob read %h", a), d, 32'h0);
        end
        wr('hFFC, 32'hDEADBEEF);
        rd('hFFC, d);
        chk("R9 oob read ffc", d, 32'h0);
        check_all("R9 window intact");

        // R3: command write with bit 0 clear changes nothing
        m[6] = 32'h1; wr('h18, 32'h1);
        wr('h08, 32'hFFFFFFFE);
        @(negedge clk);
        chk("R3 irq quiet", {31'h0, irq}, 32'h0);
        check_all("R3 no fire");

        // R4..R8: fire sweep over enable masks
        for (int k = 0; k < 7; k++) begin
            logic [31:0] e;
            e = en_list[k];
            m[8] = pat(8, k + 1);  wr('h20, m[8]);
            m[12] = pat(12, k + 1); wr('h30, m[12]);
            m[6] = e; wr('h18, e);
            wr('h08, 32'h1 | (32'(k) << 4));
            chk($sformatf("R8 lag k%0d", k), {31'h0, irq}, 32'h0);
            @(negedge clk);
            m_sts = e & 32'h1;
            m[8] = 32'h40; m[12] = 32'h40;
            chk($sformatf("R8 irq k%0d", k), {31'h0, irq}, {31'h0, m_sts != 0});
            rd('h1C, d); chk($sformatf("R5 sts k%0d", k), d, m_sts);
            rd('h20, d); chk($sformatf("R4 txb k%0d", k), d, 32'h40);
            rd('h30, d); chk($sformatf("R4 rxb k%0d", k), d, 32'h40);
            rd('h08, d); chk($sformatf("R3 cmd k%0d", k), d, 32'h0);
            if (m_sts != 0) begin
                // R6: blocked fire
                m[8] = pat(8, 40 + k);  wr('h20, m[8]);
                m[12] = pat(12, 40 + k); wr('h30, m[12]);
                wr('h08, 32'h1);
                rd('h20, d); chk($sformatf("R6 txb k%0d", k), d, m[8]);
                rd('h30, d); chk($sformatf("R6 rxb k%0d", k), d, m[12]);
                rd('h1C, d); chk($sformatf("R6 sts k%0d", k), d, m_sts);
                // R7: clear with bit 0 low keeps status
                wr('h1C, 32'hFFFFFFFE);
                rd('h1C, d); chk($sformatf("R7 partial k%0d", k), d, m_sts);
                chk($sformatf("R8 still k%0d", k), {31'h0, irq}, 32'h1);
                wr('h1C, 32'h1);
                m_sts = 32'h0;
                chk($sformatf("R8 fall lag k%0d", k), {31'h0, irq}, 32'h1);
                @(negedge clk);
                chk($sformatf("R8 fall k%0d", k), {31'h0, irq}, 32'h0);
                rd('h1C, d); chk($sformatf("R7 clear k%0d", k), d, 32'h0);
            end else begin
                wr('h1C, 32'hFFFFFFFF);
                rd('h1C, d); chk($sformatf("R7 stays zero k%0d", k), d, 32'h0);
            end
        end
        check_all("R2 final");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule